// File: doc/BRIEF.md
# Receive Elastic Bit Buffer

This block carries a serial receive bit stream from the clock recovered off the line into the local clock domain. The recovered stream and the local clock differ by up to ±500 ppm. Across a maximum-size packet this drift adds up to ±12 bit times. The buffer is a bit-wide elastic FIFO that absorbs that drift. It is written with a data bit and a valid strobe on the recovered clock. Its output is a registered bit and a valid flag on the local clock, which feed the line decoder.

At the start of every packet, the read side waits until the fill level reaches a centre threshold (16 of 32 entries by default). This leaves room to absorb drift in both directions. Once streaming, the read side takes one bit on each local clock. A write into a full buffer is an overflow, and a read demand on an empty buffer is an underflow. Either one raises a receive error that is aligned to the local clock and stays high. The downstream logic pulses a flush input at end-of-packet or idle. The flush drops the remaining contents, clears the error and re-arms the threshold wait. Pointers cross between the two domains in Gray code through two-flop synchronizers.

Top module: `rxElasticBuf`

## Requirements
- R1: After reset, rdValid and rxErr are 0.
- R2: Bits leave on rdBit in the order they were written on wrBit, with none lost or repeated, while no error occurs.
- R3: After reset or a flush, rdValid stays 0 until at least THRESH (default 16) written bits are visible to the read side.
- R4: Once streaming, the block delivers one bit on every rdClk cycle in which the buffer holds data, so rdValid has no gaps while data remains.
- R5: A write while the buffer holds DEPTH (default 32) bits is dropped and sets rxErr within a few rdClk cycles.
- R6: When the read side is streaming and the buffer is empty, rxErr is set on the next rdClk edge, and no bit is taken from the empty buffer.
- R7: rxErr remains 1 once set, until a flush.
- R8: A flush (flushReq high at an rdClk edge) discards all buffered bits, clears rxErr and rdValid on that edge, and re-arms the threshold wait of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Recovered bit clock (write side) |
| wrBit | input | 1 | Recovered serial data bit |
| wrValid | input | 1 | wrBit is valid on this wrClk edge |
| rdClk | input | 1 | Local clock (read side) |
| rstN | input | 1 | Asynchronous reset, active low, for both domains |
| flushReq | input | 1 | End-of-packet or idle: flush and re-arm (rdClk domain) |
| rdBit | output | 1 | Data bit delivered to the decoder |
| rdValid | output | 1 | rdBit holds a new bit this cycle |
| rxErr | output | 1 | Sticky overflow or underflow error, rdClk aligned |

## Verification
On every cycle the assertions check the following. Streaming starts only from a fill at or above the threshold, and a pop never meets an empty buffer. A streaming read side pops whenever data is present. An empty streaming buffer raises the error, and the error holds until a flush. A write into a full buffer leaves the write pointer unchanged, and a flush silences the output. Only the bench scenarios can show that bit order survives the domain crossing, that a flush really drops old bits so that the next packet starts clean, and that a fast writer produces an error in the local domain. They use two independent clocks, including a writer briefly five times faster than the reader.

// File: rtl/rxEbufPkg.sv
`timescale 1ns/1ps
package rxEbufPkg;

  typedef struct packed {
    logic pop;
    logic flush;
  } ebufStrobes_t;

  typedef enum logic {
    ARMED     = 1'b0,
    STREAMING = 1'b1
  } rdState_t;

endpackage

// File: rtl/rxEbufSync.sv
`timescale 1ns/1ps
module rxEbufSync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dOut   <= '0;
    end else begin
      stage1 <= dIn;
      dOut   <= stage1;
    end
  end
endmodule

// File: rtl/rxEbufDatapath.sv
`timescale 1ns/1ps
module rxEbufDatapath import rxEbufPkg::*; #(
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrBit,
  input  logic          wrValid,
  input  ebufStrobes_t  strobes,
  output logic [PW-1:0] fill,
  output logic          ovfPulse,
  output logic          rdBit,
  output logic          rdValid
);
  logic [DEPTH-1:0] mem;
  logic [PW-1:0] wrPtrBin, wrPtrGray, rdPtrGrayW, rdPtrBinW;
  logic [PW-1:0] rdPtrBin, rdPtrGray, wrPtrGrayR, wrPtrBinR;
  logic wrFull, ovfToggle, ovfSyncd, ovfSeen;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  assign rdPtrBinW = fromGray(rdPtrGrayW);
  assign wrFull    = (wrPtrBin - rdPtrBinW) == PW'(DEPTH);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtrBin  <= '0;
      wrPtrGray <= '0;
      ovfToggle <= 1'b0;
    end else if (wrValid) begin
      if (wrFull) begin
        ovfToggle <= ~ovfToggle;
      end else begin
        wrPtrBin  <= wrPtrBin + PW'(1);
        wrPtrGray <= toGray(wrPtrBin + PW'(1));
      end
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrValid && !wrFull) mem[wrPtrBin[AW-1:0]] <= wrBit;
  end

  // crossings
  rxEbufSync #(.W(PW)) uRdToWr (.clk(wrClk), .rstN(rstN), .dIn(rdPtrGray), .dOut(rdPtrGrayW));
  rxEbufSync #(.W(PW)) uWrToRd (.clk(rdClk), .rstN(rstN), .dIn(wrPtrGray), .dOut(wrPtrGrayR));
  rxEbufSync #(.W(1))  uOvf    (.clk(rdClk), .rstN(rstN), .dIn(ovfToggle), .dOut(ovfSyncd));

  // read domain
  assign wrPtrBinR = fromGray(wrPtrGrayR);
  assign fill      = wrPtrBinR - rdPtrBin;
  assign ovfPulse  = ovfSyncd ^ ovfSeen;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtrBin  <= '0;
      rdPtrGray <= '0;
      ovfSeen   <= 1'b0;
      rdBit     <= 1'b0;
      rdValid   <= 1'b0;
    end else begin
      ovfSeen <= ovfSyncd;
      rdValid <= strobes.pop && !strobes.flush;
      if (strobes.flush) begin
        rdPtrBin  <= wrPtrBinR;
        rdPtrGray <= toGray(wrPtrBinR);
      end else if (strobes.pop) begin
        rdBit     <= mem[rdPtrBin[AW-1:0]];
        rdPtrBin  <= rdPtrBin + PW'(1);
        rdPtrGray <= toGray(rdPtrBin + PW'(1));
      end
    end
  end

  AST_NO_EMPTY_POP: assert property (@(posedge rdClk) disable iff (!rstN)
    strobes.pop |-> fill != '0);                                  // R6
  AST_HOLD_WHEN_FULL: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrValid && wrFull) |=> $stable(wrPtrBin));                   // R5
  AST_FLUSH_QUIET: assert property (@(posedge rdClk) disable iff (!rstN)
    strobes.flush |=> !rdValid);                                  // R8
endmodule

// File: rtl/rxEbufControl.sv
`timescale 1ns/1ps
module rxEbufControl import rxEbufPkg::*; #(
  parameter  int DEPTH  = 32,
  parameter  int THRESH = 16,
  localparam int PW     = $clog2(DEPTH) + 1
) (
  input  logic          rdClk,
  input  logic          rstN,
  input  logic [PW-1:0] fill,
  input  logic          ovfPulse,
  input  logic          flushReq,
  output ebufStrobes_t  strobes,
  output logic          rxErr
);
  rdState_t state;
  logic running, isEmpty;

  assign running = (state == STREAMING);
  assign isEmpty = (fill == '0);

  always_comb begin
    strobes.flush = flushReq;
    strobes.pop   = !flushReq && running && !isEmpty;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      state <= ARMED;
      rxErr <= 1'b0;
    end else if (flushReq) begin
      state <= ARMED;
      rxErr <= 1'b0;
    end else begin
      if (!running && fill >= PW'(THRESH)) state <= STREAMING;
      if ((running && isEmpty) || ovfPulse) rxErr <= 1'b1;
    end
  end

  AST_START_AT_THRESH: assert property (@(posedge rdClk) disable iff (!rstN)
    $rose(running) |-> $past(fill) >= PW'(THRESH));               // R3
  AST_STREAM_STEADY: assert property (@(posedge rdClk) disable iff (!rstN)
    (running && !isEmpty && !flushReq) |-> strobes.pop);          // R4
  AST_UNDERFLOW_FLAG: assert property (@(posedge rdClk) disable iff (!rstN)
    (running && isEmpty && !flushReq) |=> rxErr);                 // R6
  AST_ERR_STICKY: assert property (@(posedge rdClk) disable iff (!rstN)
    (rxErr && !flushReq) |=> rxErr);                              // R7
endmodule

// File: rtl/rxElasticBuf.sv
`timescale 1ns/1ps
module rxElasticBuf import rxEbufPkg::*; #(
  parameter  int DEPTH  = 32,
  parameter  int THRESH = 16,
  localparam int PW     = $clog2(DEPTH) + 1
) (
  input  logic wrClk,
  input  logic wrBit,
  input  logic wrValid,
  input  logic rdClk,
  input  logic rstN,
  input  logic flushReq,
  output logic rdBit,
  output logic rdValid,
  output logic rxErr
);
  ebufStrobes_t  strobes;
  logic [PW-1:0] fill;
  logic          ovfPulse;

  rxEbufDatapath #(.DEPTH(DEPTH)) uPath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrBit(wrBit), .wrValid(wrValid), .strobes(strobes),
    .fill(fill), .ovfPulse(ovfPulse), .rdBit(rdBit), .rdValid(rdValid)
  );

  rxEbufControl #(.DEPTH(DEPTH), .THRESH(THRESH)) uCtrl (
    .rdClk(rdClk), .rstN(rstN), .fill(fill), .ovfPulse(ovfPulse),
    .flushReq(flushReq), .strobes(strobes), .rxErr(rxErr)
  );
endmodule

// File: tb/tb_rxElasticBuf.sv
`timescale 1ns/1ps
module tb_rxElasticBuf;
  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic wrBit = 0, wrValid = 0, flushReq = 0;
  logic rdBit, rdValid, rxErr;
  real  wrHalf = 2.45;

  int checks = 0, errors = 0;
  int readsCnt = 0, mism = 0, gaps = 0;
  bit started = 0;
  bit expQ[$];

  // {nBits[31:16], gapEvery[15:8], pattern[7:0]}
  localparam logic [31:0] VECS [5] = '{
    {16'd40, 8'd0,  8'hA5},
    {16'd64, 8'd0,  8'h3C},
    {16'd24, 8'd8,  8'hF0},
    {16'd90, 8'd16, 8'h81},
    {16'd33, 8'd5,  8'h6E}
  };

  rxElasticBuf dut (
    .wrClk(wrClk), .wrBit(wrBit), .wrValid(wrValid), .rdClk(rdClk),
    .rstN(rstN), .flushReq(flushReq), .rdBit(rdBit), .rdValid(rdValid), .rxErr(rxErr)
  );

  always #2.5 rdClk = ~rdClk;      // 200 MHz local clock
  always #(wrHalf) wrClk = ~wrClk; // recovered clock

  always @(negedge rdClk) begin
    if (rdValid) begin
      readsCnt++;
      started = 1;
      if (expQ.size() == 0) mism++;
      else if (expQ.pop_front() != rdBit) mism++;
    end else if (started) begin
      gaps++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeBits(input int n, input logic [7:0] pat, input int gapEvery);
    for (int i = 0; i < n; i++) begin
      if (gapEvery != 0 && (i % gapEvery) == gapEvery - 1) begin
        @(negedge wrClk); wrValid = 0;
      end
      @(negedge wrClk);
      wrValid = 1;
      wrBit   = pat[i % 8];
      expQ.push_back(pat[i % 8]);
    end
    @(negedge wrClk); wrValid = 0;
  endtask

  task automatic rdWait(input int n);
    for (int i = 0; i < n; i++) @(posedge rdClk);
    #1;
  endtask

  task automatic waitReads(input int target);
    for (int i = 0; i < 2000 && readsCnt < target; i++) rdWait(1);
  endtask

  task automatic clearStats();
    readsCnt = 0; mism = 0; gaps = 0; started = 0;
  endtask

  task automatic doFlush();
    @(posedge rdClk); #1 flushReq = 1;
    @(posedge rdClk); #1 flushReq = 0;
    expQ.delete();
    started = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12 rstN = 1;
    rdWait(2);
    check(rdValid == 0, "R1", "rdValid after reset", rdValid, 0);
    check(rxErr == 0,   "R1", "rxErr after reset",   rxErr,   0);

    // vector table: packets of varied length, pattern and write gaps
    foreach (VECS[v]) begin
      clearStats();
      writeBits(int'(VECS[v][31:16]), VECS[v][7:0], int'(VECS[v][15:8]));
      waitReads(int'(VECS[v][31:16]) - 4);
      check(readsCnt >= int'(VECS[v][31:16]) - 4, "R2", "bits delivered",
            readsCnt, int'(VECS[v][31:16]) - 4);
      check(mism == 0, "R2", "bit order mismatches", mism, 0);
      check(gaps == 0, "R4", "rdValid gaps while data held", gaps, 0);
      check(rxErr == 0, "R5", "no error on normal packet", rxErr, 0);
      doFlush();
      check(rdValid == 0 && rxErr == 0, "R8", "quiet after flush",
            {rdValid, rxErr}, 0);
    end

    // threshold wait and underflow
    clearStats();
    writeBits(15, 8'hC3, 0);
    rdWait(30);
    check(readsCnt == 0, "R3", "no reads below threshold", readsCnt, 0);
    writeBits(5, 8'h5A, 0);
    for (int i = 0; i < 100 && !rxErr; i++) rdWait(1);
    check(rxErr == 1, "R6", "underflow sets rxErr", rxErr, 1);
    check(readsCnt == 20 && mism == 0, "R2", "all bits out in order before underflow",
          readsCnt, 20);
    rdWait(30);
    check(rxErr == 1, "R7", "rxErr sticky after underflow", rxErr, 1);
    doFlush();
    check(rxErr == 0, "R8", "flush clears rxErr", rxErr, 0);

    // flush discards held bits and re-arms threshold
    clearStats();
    writeBits(10, 8'hFF, 0);
    rdWait(10);
    doFlush();
    clearStats();
    writeBits(10, 8'h00, 0);
    rdWait(20);
    check(readsCnt == 0, "R8", "threshold re-armed after flush", readsCnt, 0);
    writeBits(6, 8'h00, 0);
    waitReads(12);
    check(readsCnt >= 12 && mism == 0, "R8", "old bits discarded by flush", mism, 0);
    doFlush();

    // overflow with a writer five times faster
    clearStats();
    wrHalf = 0.5;
    writeBits(60, 8'h99, 0);
    rdWait(5);
    check(rxErr == 1, "R5", "overflow sets rxErr", rxErr, 1);
    rdWait(20);
    check(rxErr == 1, "R7", "rxErr sticky after overflow", rxErr, 1);
    doFlush();
    wrHalf = 2.45;
    rdWait(3);
    check(rxErr == 0 && rdValid == 0, "R8", "flush clears overflow", {rxErr, rdValid}, 0);

    // recovery packet after overflow
    clearStats();
    writeBits(30, 8'h2D, 0);
    waitReads(26);
    check(readsCnt >= 26 && mism == 0, "R2", "clean packet after overflow", mism, 0);
    check(rxErr == 0, "R5", "no error after recovery", rxErr, 0);
    doFlush();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule